// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block collapses a 32-bit vector of level-sensitive interrupt lines into four combined request lines, one for each group of eight neighbouring lines. A parent interrupt controller sees only the four combined lines. When one of them fires, software reads the status word and works out which source in the group is active.

Each line passes through a two-flop synchronizer and is then gated by its own enable bit. Software never rewrites the enable word with a read-modify-write. It writes a one-hot or multi-bit mask to a set word to turn lines on, or to a clear word to turn them off. At start-up it usually writes each group's byte mask to the clear word.

Several banks can be placed 0x10 bytes apart, so that combined line n is served by bank n/4 and lies in byte lane n%4 of that bank's words.

Top module: `irq_combiner_bank`

## Requirements
- R1: After reset, every enable bit is 0, every group output is 0, and the status word reads 0.
- R2: A write to word offset 0x0 sets each enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R3: A write to word offset 0x4 clears each enable bit whose data bit is 1 and leaves every other enable bit unchanged. Writing a group's byte mask there disables exactly that group.
- R4: A read of offset 0xC returns the status word. Status bit i is 1 only when input i (after synchronization) is 1 and enable bit i is 1.
- R5: Reads of offsets 0x0 and 0x4 return the current enable word. Reads of offset 0x8, or of any offset with address bits [1:0] not equal to 0, return 0.
- R6: Writes to offset 0xC, to offset 0x8, and to misaligned offsets leave the enable word unchanged.
- R7: Group output g is the registered OR of status bits [8g+7:8g]. A change of an enable bit committed at a clock edge reaches the group output at the following edge. Each group is independent of the others.
- R8: An input change that is present before clock edge k shows up in the status word after edge k+1 and on the group output after edge k+2.
- R9: A group output stays high for as long as any enabled input of that group stays high, and drops once those inputs fall or are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt source lines, asynchronous to clk |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Byte offset within the bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| group_irq | output | 4 | Combined request line of each group of eight sources |

## Verification
Two events can land in the same cycle: a clear write can commit at the very edge where a freshly synchronized input rises. The bench provokes this by raising an enabled input one cycle before it issues the clear write, so that the synchronizer's second stage and the enable register update together. It then judges the result by requiring that the affected group output stays low at every sample taken over the following cycles. A single-cycle pulse would show up there as a spurious interrupt.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

   // word slots within one bank, selected by byte offset bits [3:2]
   typedef enum logic [1:0] {
      SLOT_EN_SET = 2'd0,
      SLOT_EN_CLR = 2'd1,
      SLOT_RSVD   = 2'd2,
      SLOT_STATUS = 2'd3
   } reg_slot_e;

   function automatic reg_slot_e slot_of(input logic [3:0] byte_off);
      return reg_slot_e'(byte_off[3:2]);
   endfunction

   function automatic logic is_aligned(input logic [3:0] byte_off);
      return byte_off[1:0] == 2'b00;
   endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   initial begin
      if (STAGES < 2) $error("irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] en_o
);

   logic [WIDTH-1:0] set_m;
   logic [WIDTH-1:0] clr_m;

   always_comb begin
      set_m = set_stb ? mask_i : '0;
      clr_m = clr_stb ? mask_i : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_o <= '0;
      else        en_o <= (en_o | set_m) & ~clr_m;
   end

   // R2
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((en_o & $past(mask_i)) == $past(mask_i)));

   // R3
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((en_o & $past(mask_i)) == '0));

   // R6
   hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_stb || clr_stb) |=> $stable(en_o));

endmodule

// File: rtl/irq_group_or.sv
module irq_group_or #(
   parameter int unsigned SRC     = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [SRC-1:0] stat_i,
   output logic           grp_o
);

   logic any_w;
   assign any_w = |stat_i;

   generate
      if (OUT_REG) begin : g_reg
         logic grp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) grp_q <= 1'b0;
            else        grp_q <= any_w;
         end
         assign grp_o = grp_q;

         // R7
         grp_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (grp_o == (|$past(stat_i))));
      end else begin : g_comb
         assign grp_o = any_w;
      end
   endgenerate

endmodule

// File: rtl/irq_combiner_bank.sv
module irq_combiner_bank
   import irq_comb_pkg::*;
#(
   parameter int unsigned GROUPS        = 4,
   parameter int unsigned SRC_PER_GROUP = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          OUT_REG       = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [GROUPS*SRC_PER_GROUP-1:0]   irq_in,
   input  logic                              reg_wr,
   input  logic [3:0]                        reg_addr,
   input  logic [GROUPS*SRC_PER_GROUP-1:0]   reg_wdata,
   output logic [GROUPS*SRC_PER_GROUP-1:0]   reg_rdata,
   output logic [GROUPS-1:0]                 group_irq
);

   localparam int unsigned WIDTH = GROUPS * SRC_PER_GROUP;

   initial begin
      if (GROUPS < 1)        $error("irq_combiner_bank: GROUPS must be >= 1");
      if (SRC_PER_GROUP < 1) $error("irq_combiner_bank: SRC_PER_GROUP must be >= 1");
      if (WIDTH > 32)        $error("irq_combiner_bank: bank word exceeds 32 bits");
   end

   logic [WIDTH-1:0] sync_w;
   logic [WIDTH-1:0] en_w;
   logic [WIDTH-1:0] status_w;
   logic             hit_w;
   reg_slot_e        slot_w;
   logic             set_stb;
   logic             clr_stb;

   irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_in),
      .sync_o  (sync_w)
   );

   always_comb begin
      hit_w   = is_aligned(reg_addr);
      slot_w  = slot_of(reg_addr);
      set_stb = reg_wr && hit_w && (slot_w == SLOT_EN_SET);
      clr_stb = reg_wr && hit_w && (slot_w == SLOT_EN_CLR);
   end

   irq_enable_reg #(.WIDTH(WIDTH)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .mask_i  (reg_wdata),
      .en_o    (en_w)
   );

   assign status_w = sync_w & en_w;

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         irq_group_or #(.SRC(SRC_PER_GROUP), .OUT_REG(OUT_REG)) u_or (
            .clk    (clk),
            .rst_n  (rst_n),
            .stat_i (status_w[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
            .grp_o  (group_irq[g])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (hit_w) begin
         unique case (slot_w)
            SLOT_EN_SET, SLOT_EN_CLR: reg_rdata = en_w;
            SLOT_STATUS:              reg_rdata = status_w;
            default:                  reg_rdata = '0;
         endcase
      end
   end

   // R4
   status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_w && slot_w == SLOT_STATUS) |-> ((reg_rdata & ~en_w) == '0));

endmodule

// File: tb/test_irq_combiner_bank.sv
module test_irq_combiner_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  group_irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      bit          is_grp;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   always #5 clk = ~clk;

   irq_combiner_bank i_irq_combiner_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .group_irq (group_irq)
   );

   // monitor: compares every queued item at the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_grp ? {28'd0, group_irq} : reg_rdata;
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      reg_addr = a;
      it.is_grp = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic push_grp(input logic [3:0] e, input string tag);
      item_t it;
      it.is_grp = 1'b1; it.exp = {28'd0, e}; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
      push_rd(a, e, tag);
      settle();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got %h exp %h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      push_grp(4'h0, "R1 group after reset");
      rd_chk(4'h0, 32'h0, "R1 enable after reset");
      rd_chk(4'hC, 32'h0, "R1 status after reset");

      // R2 set register
      wr(4'h0, 32'hA500_FF01);
      rd_chk(4'h0, 32'hA500_FF01, "R2 set first mask");
      wr(4'h0, 32'h00F0_0000);
      rd_chk(4'h0, 32'hA5F0_FF01, "R2 set keeps other bits");
      // R5 read of clear slot shows enable
      rd_chk(4'h4, 32'hA5F0_FF01, "R5 clear slot reads enable");

      // R3 clear register, including a group byte mask
      wr(4'h4, 32'h0000_00FF);
      rd_chk(4'h0, 32'hA5F0_FF00, "R3 clear low byte");
      wr(4'h4, 32'h00FF_0000);
      rd_chk(4'h0, 32'hA500_FF00, "R3 clear group 2 byte mask");

      // R6 writes to status, reserved and misaligned offsets
      wr(4'hC, 32'hFFFF_FFFF);
      wr(4'h8, 32'h0000_0000);
      wr(4'h1, 32'hFFFF_FFFF);
      wr(4'h5, 32'hFFFF_FFFF);
      rd_chk(4'h0, 32'hA500_FF00, "R6 ignored writes");
      // R5 reserved and misaligned reads
      rd_chk(4'h8, 32'h0, "R5 reserved reads zero");
      rd_chk(4'h2, 32'h0, "R5 misaligned reads zero");

      // R8 latency of input path, R4 status masking, R7 grouping
      @(posedge clk); #1;
      irq_in = 32'h0F12_3401;
      push_rd(4'hC, 32'h0, "R8 status before sync");
      @(posedge clk); #1;
      push_rd(4'hC, 32'h0, "R8 status one edge");
      push_grp(4'h0, "R8 group one edge");
      settle();
      push_rd(4'hC, 32'h0500_3400, "R4 R8 status after two edges");
      push_grp(4'h0, "R8 group after two edges");
      settle();
      push_grp(4'hA, "R7 R8 group after three edges");
      settle();

      // R9 level hold
      repeat (10) @(posedge clk);
      #1;
      push_grp(4'hA, "R9 group held");
      settle();
      irq_in = 32'h0012_3401;
      repeat (3) @(posedge clk);
      #1;
      push_grp(4'h2, "R9 group 3 falls");
      rd_chk(4'hC, 32'h0000_3400, "R4 status after fall");

      // R7 enable change reaches group one edge later
      wr(4'h4, 32'h0000_FF00);
      push_grp(4'h2, "R7 group right after clear");
      settle();
      push_grp(4'h0, "R7 group one edge after clear");
      settle();
      // R7 group 0 alone
      wr(4'h0, 32'h0000_0001);
      settle();
      push_grp(4'h1, "R7 group 0 alone");
      settle();

      // collision: synchronized rise and clear commit at the same edge
      irq_in = 32'h0;
      wr(4'h4, 32'hFFFF_FFFF);
      wr(4'h0, 32'h0100_0000);
      repeat (3) @(posedge clk);
      #1;
      irq_in = 32'h0100_0000;
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h0100_0000;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      for (int n = 0; n < 4; n++) begin
         push_grp(4'h0, "R9 no pulse on clear collision");
         settle();
      end
      rd_chk(4'hC, 32'h0, "R4 status zero after collision");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule